// File: doc/BRIEF.md
# Accumulator ALU with Flag Logic

This block is the 8-bit accumulator datapath of a small controller that interprets a byte-coded instruction stream. Fetch, decode and memory access live elsewhere. Each cycle the decoder presents an operation code, the current accumulator, one operand byte, and the present zero (Z) and carry (C) flags. The operand byte can come from an immediate, a working register or a register-file byte. The block returns a new accumulator, Z and C value together with a write enable for each. When an enable is low, the matching output simply repeats its input, so the surrounding register file may latch either way.

All arithmetic and logic paths are combinational. The only state is a one-entry shadow of the two flags. It has two actions: a capture (SAVE, loaded on the clock edge) and a restore (REST, read back combinationally in any later cycle). The shadow is clocked and is cleared by an active-low synchronous reset. Carry follows a "no borrow" convention on subtraction and comparison. The conditional add and subtract take their condition from C.

A compatibility input selects an older flag behaviour. In that mode, loading the accumulator from a working register leaves Z untouched.

Top module: `acc_alu_core`

## Requirements
- R1: The operation code is 5 bits. Code 0 (NOP) and the unused codes 17 to 31 raise no write enable. With any enable low, the matching output equals its input (acc_out=acc_in, z_out=z_in, c_out=c_in).
- R2: INC (code 1) writes A+1 modulo 256. C is 1 only when A was 0xFF, and Z is set when the result is zero. All three enables are high.
- R3: DEC (code 2) writes A-1 modulo 256. C is 1 when A was at least 1 (no borrow), and Z is set from the result. All three enables are high.
- R4: ADD (code 3) writes A+operand modulo 256. C is the carry out of bit 7, and Z is set from the result.
- R5: SUB (code 4) writes A-operand modulo 256. C is 1 when A is greater than or equal to the operand, and Z is set from the result.
- R6: CMP (code 5) writes Z=(A==operand) and C=(A>=operand) and leaves A unwritten.
- R7: XOR (code 6) writes A^operand and sets Z from it. It always writes C as 0.
- R8: CPL (code 7) writes ~A with no flag enable. TST (code 10) writes only Z=(A==0). CLR (code 11) writes A=0 and Z=1 and leaves C unwritten.
- R9: ROR (code 8) writes A rotated right by one and C=A bit 0. ROL (code 9) writes A rotated left by one and C=A bit 7. Z is not written by either.
- R10: LDR (code 12) writes A=operand with C unwritten. With legacy_mode=0 it also writes Z=(operand==0). With legacy_mode=1, Z is not written.
- R11: ADDC (code 13) acts as INC when C=1 and writes nothing when C=0. SUBNC (code 14) acts as DEC when C=0 and writes nothing when C=1.
- R12: SAVE (code 15) captures Z and C into the shadow on the clock edge and raises no enable. REST (code 16) writes Z and C from the shadow in the same cycle. After reset the shadow holds Z=0 and C=0, and other operations leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag shadow |
| rst_n | input | 1 | Active-low synchronous reset of the flag shadow |
| op_code | input | 5 | Decoded operation code |
| legacy_mode | input | 1 | 1 selects the older register-load flag behaviour |
| acc_in | input | 8 | Current accumulator |
| opnd_in | input | 8 | Operand byte |
| z_in | input | 1 | Current zero flag |
| c_in | input | 1 | Current carry flag |
| acc_out | output | 8 | New accumulator value |
| acc_we | output | 1 | Accumulator write enable |
| z_out | output | 1 | New zero flag |
| z_we | output | 1 | Zero flag write enable |
| c_out | output | 1 | New carry flag |
| c_we | output | 1 | Carry flag write enable |

## Verification
Every result except the shadow capture is combinational, so it is due in the same cycle as its operands. The bench drives each operation on a falling edge and samples 1 ns later, well before the next rising edge. A SAVE only takes effect at the following rising edge. Each save/restore test therefore drives SAVE on one falling edge and REST (or an intervening operation) on a later falling edge, so the restored flags are read one full edge after the capture.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int OPW = 5;

    typedef enum logic [OPW-1:0] {
        OP_NOP   = 5'd0,
        OP_INC   = 5'd1,
        OP_DEC   = 5'd2,
        OP_ADD   = 5'd3,
        OP_SUB   = 5'd4,
        OP_CMP   = 5'd5,
        OP_XOR   = 5'd6,
        OP_CPL   = 5'd7,
        OP_ROR   = 5'd8,
        OP_ROL   = 5'd9,
        OP_TST   = 5'd10,
        OP_CLR   = 5'd11,
        OP_LDR   = 5'd12,
        OP_ADDC  = 5'd13,
        OP_SUBNC = 5'd14,
        OP_SAVE  = 5'd15,
        OP_REST  = 5'd16
    } op_e;

endpackage

// File: rtl/acc_arith.sv
module acc_arith
    import acc_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  op_e           op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          c_in,
    output logic [DW-1:0] res,
    output logic          z,
    output logic          c
);

    localparam logic [DW-1:0] ONE     = DW'(1);
    localparam logic [DW-1:0] ALLONES = '1;

    logic [DW:0]   sum_ab;
    logic [DW-1:0] diff_ab;
    logic [DW-1:0] inc_v;
    logic [DW-1:0] dec_v;
    logic          a_ge_b;

    assign sum_ab  = {1'b0, a} + {1'b0, b};
    assign diff_ab = a - b;
    assign inc_v   = a + ONE;
    assign dec_v   = a - ONE;
    assign a_ge_b  = (a >= b);

    always_comb begin
        res = a;
        c   = c_in;
        unique case (op)
            OP_INC, OP_ADDC: begin
                res = inc_v;
                c   = (a == ALLONES);
            end
            OP_DEC, OP_SUBNC: begin
                res = dec_v;
                c   = (a != '0);
            end
            OP_ADD: begin
                res = sum_ab[DW-1:0];
                c   = sum_ab[DW];
            end
            OP_SUB, OP_CMP: begin
                res = diff_ab;
                c   = a_ge_b;
            end
            default: begin
                res = a;
                c   = c_in;
            end
        endcase
        z = (res == '0);
    end

endmodule

// File: rtl/acc_logic.sv
module acc_logic
    import acc_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  op_e           op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] res,
    output logic          z,
    output logic          c
);

    always_comb begin
        res = a;
        c   = 1'b0;
        unique case (op)
            OP_XOR: res = a ^ b;
            OP_CPL: res = ~a;
            OP_ROR: begin
                res = {a[0], a[DW-1:1]};
                c   = a[0];
            end
            OP_ROL: begin
                res = {a[DW-2:0], a[DW-1]};
                c   = a[DW-1];
            end
            OP_CLR: res = '0;
            OP_LDR: res = b;
            default: res = a;
        endcase
        z = (res == '0);
    end

endmodule

// File: rtl/acc_flag_shadow.sv
module acc_flag_shadow (
    input  logic clk,
    input  logic rst_n,
    input  logic save_en,
    input  logic z_in,
    input  logic c_in,
    output logic z_held,
    output logic c_held
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            z_held <= 1'b0;
            c_held <= 1'b0;
        end else if (save_en) begin
            z_held <= z_in;
            c_held <= c_in;
        end
    end

    // R12
    shadow_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(save_en)) |-> (z_held == $past(z_in) && c_held == $past(c_in)))
        else $error("shadow did not capture flags");

    // R12
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(save_en)) |-> ($stable(z_held) && $stable(c_held)))
        else $error("shadow changed without save");

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
    import acc_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [4:0]    op_code,
    input  logic          legacy_mode,
    input  logic [DW-1:0] acc_in,
    input  logic [DW-1:0] opnd_in,
    input  logic          z_in,
    input  logic          c_in,
    output logic [DW-1:0] acc_out,
    output logic          acc_we,
    output logic          z_out,
    output logic          z_we,
    output logic          c_out,
    output logic          c_we
);

    op_e           op;
    logic [DW-1:0] ar_res;
    logic          ar_z;
    logic          ar_c;
    logic [DW-1:0] lg_res;
    logic          lg_z;
    logic          lg_c;
    logic          sh_z;
    logic          sh_c;
    logic          save_en;

    assign op      = op_e'(op_code);
    assign save_en = (op == OP_SAVE);

    acc_arith #(.DW(DW)) u_arith (
        .op   (op),
        .a    (acc_in),
        .b    (opnd_in),
        .c_in (c_in),
        .res  (ar_res),
        .z    (ar_z),
        .c    (ar_c)
    );

    acc_logic #(.DW(DW)) u_logic (
        .op  (op),
        .a   (acc_in),
        .b   (opnd_in),
        .res (lg_res),
        .z   (lg_z),
        .c   (lg_c)
    );

    acc_flag_shadow u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .save_en (save_en),
        .z_in    (z_in),
        .c_in    (c_in),
        .z_held  (sh_z),
        .c_held  (sh_c)
    );

    always_comb begin
        acc_out = acc_in;
        z_out   = z_in;
        c_out   = c_in;
        acc_we  = 1'b0;
        z_we    = 1'b0;
        c_we    = 1'b0;
        unique case (op)
            OP_INC, OP_DEC, OP_ADD, OP_SUB: begin
                acc_out = ar_res; acc_we = 1'b1;
                z_out   = ar_z;   z_we   = 1'b1;
                c_out   = ar_c;   c_we   = 1'b1;
            end
            OP_CMP: begin
                z_out = ar_z; z_we = 1'b1;
                c_out = ar_c; c_we = 1'b1;
            end
            OP_ADDC: begin
                if (c_in) begin
                    acc_out = ar_res; acc_we = 1'b1;
                    z_out   = ar_z;   z_we   = 1'b1;
                    c_out   = ar_c;   c_we   = 1'b1;
                end
            end
            OP_SUBNC: begin
                if (!c_in) begin
                    acc_out = ar_res; acc_we = 1'b1;
                    z_out   = ar_z;   z_we   = 1'b1;
                    c_out   = ar_c;   c_we   = 1'b1;
                end
            end
            OP_XOR: begin
                acc_out = lg_res; acc_we = 1'b1;
                z_out   = lg_z;   z_we   = 1'b1;
                c_out   = 1'b0;   c_we   = 1'b1;
            end
            OP_CPL: begin
                acc_out = lg_res; acc_we = 1'b1;
            end
            OP_ROR, OP_ROL: begin
                acc_out = lg_res; acc_we = 1'b1;
                c_out   = lg_c;   c_we   = 1'b1;
            end
            OP_TST: begin
                z_out = lg_z; z_we = 1'b1;
            end
            OP_CLR: begin
                acc_out = lg_res; acc_we = 1'b1;
                z_out   = 1'b1;   z_we   = 1'b1;
            end
            OP_LDR: begin
                acc_out = lg_res; acc_we = 1'b1;
                if (!legacy_mode) begin
                    z_out = lg_z; z_we = 1'b1;
                end
            end
            OP_REST: begin
                z_out = sh_z; z_we = 1'b1;
                c_out = sh_c; c_we = 1'b1;
            end
            default: begin
                acc_we = 1'b0;
            end
        endcase
    end

    // R5
    sub_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OP_SUB) |-> (c_we && c_out == (acc_in >= opnd_in)))
        else $error("subtract carry is not no-borrow");

    // R6
    cmp_keep_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OP_CMP) |-> (!acc_we && acc_out == acc_in && z_out == (acc_in == opnd_in)))
        else $error("compare touched accumulator");

    // R7
    xor_carry_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OP_XOR) |-> (c_we && !c_out))
        else $error("xor left carry set");

    // R8
    cpl_flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OP_CPL) |-> (!z_we && !c_we && acc_out == ~acc_in))
        else $error("complement touched flags");

    // R10
    legacy_load_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OP_LDR && legacy_mode) |-> (!z_we && acc_out == opnd_in))
        else $error("legacy load wrote zero flag");

    // R11
    addc_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OP_ADDC && !c_in) |-> (!acc_we && !z_we && !c_we))
        else $error("carry add wrote with carry clear");

    // R12
    shadow_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OP_REST && $past(op_code) == OP_SAVE && $past(rst_n))
            |-> (z_out == $past(z_in) && c_out == $past(c_in)))
        else $error("restore did not return saved flags");

endmodule

// File: tb/sim_acc_alu_core.sv
module sim_acc_alu_core;

    localparam logic [4:0] C_NOP = 5'd0,  C_INC = 5'd1,  C_DEC = 5'd2,  C_ADD = 5'd3;
    localparam logic [4:0] C_SUB = 5'd4,  C_CMP = 5'd5,  C_XOR = 5'd6,  C_CPL = 5'd7;
    localparam logic [4:0] C_ROR = 5'd8,  C_ROL = 5'd9,  C_TST = 5'd10, C_CLR = 5'd11;
    localparam logic [4:0] C_LDR = 5'd12, C_ADDC = 5'd13, C_SUBNC = 5'd14;
    localparam logic [4:0] C_SAVE = 5'd15, C_REST = 5'd16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] op_code = 5'd0;
    logic       legacy_mode = 1'b0;
    logic [7:0] acc_in = 8'h00;
    logic [7:0] opnd_in = 8'h00;
    logic       z_in = 1'b0;
    logic       c_in = 1'b0;
    logic [7:0] acc_out;
    logic       acc_we, z_out, z_we, c_out, c_we;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    acc_alu_core u0 (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .legacy_mode(legacy_mode),
        .acc_in(acc_in), .opnd_in(opnd_in), .z_in(z_in), .c_in(c_in),
        .acc_out(acc_out), .acc_we(acc_we), .z_out(z_out), .z_we(z_we),
        .c_out(c_out), .c_we(c_we)
    );

    task automatic check(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic drive(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic z, input logic c, input logic lg);
        @(negedge clk);
        op_code = op; acc_in = a; opnd_in = b; z_in = z; c_in = c; legacy_mode = lg;
        #1;
    endtask

    task automatic expect_all(input string tag, input logic [7:0] a, input logic aw,
                              input logic z, input logic zw, input logic c, input logic cw);
        check({tag, " acc"}, acc_out, a);
        check({tag, " acc_we"}, acc_we, aw);
        check({tag, " z"}, z_out, z);
        check({tag, " z_we"}, z_we, zw);
        check({tag, " c"}, c_out, c);
        check({tag, " c_we"}, c_we, cw);
    endtask

    task automatic t_reset_and_idle();
        drive(C_REST, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0);
        expect_all("R12 reset shadow", 8'h00, 0, 0, 1, 0, 1);
        drive(C_NOP, 8'h5A, 8'h11, 1'b1, 1'b0, 1'b0);
        expect_all("R1 nop", 8'h5A, 0, 1, 0, 0, 0);
        drive(5'd31, 8'hA5, 8'h22, 1'b0, 1'b1, 1'b0);
        expect_all("R1 unused31", 8'hA5, 0, 0, 0, 1, 0);
        drive(5'd17, 8'h01, 8'h22, 1'b1, 1'b1, 1'b1);
        expect_all("R1 unused17", 8'h01, 0, 1, 0, 1, 0);
    endtask

    task automatic t_inc_dec();
        drive(C_INC, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b0);
        expect_all("R2 inc wrap", 8'h00, 1, 1, 1, 1, 1);
        drive(C_INC, 8'h41, 8'h00, 1'b1, 1'b1, 1'b0);
        expect_all("R2 inc plain", 8'h42, 1, 0, 1, 0, 1);
        drive(C_DEC, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0);
        expect_all("R3 dec borrow", 8'hFF, 1, 0, 1, 0, 1);
        drive(C_DEC, 8'h01, 8'h00, 1'b0, 1'b0, 1'b0);
        expect_all("R3 dec to zero", 8'h00, 1, 1, 1, 1, 1);
    endtask

    task automatic t_add_sub();
        drive(C_ADD, 8'h80, 8'h80, 1'b0, 1'b0, 1'b0);
        expect_all("R4 add carry", 8'h00, 1, 1, 1, 1, 1);
        drive(C_ADD, 8'h12, 8'h34, 1'b1, 1'b1, 1'b0);
        expect_all("R4 add plain", 8'h46, 1, 0, 1, 0, 1);
        drive(C_SUB, 8'h05, 8'h05, 1'b0, 1'b0, 1'b0);
        expect_all("R5 sub equal", 8'h00, 1, 1, 1, 1, 1);
        drive(C_SUB, 8'h03, 8'h07, 1'b1, 1'b1, 1'b0);
        expect_all("R5 sub borrow", 8'hFC, 1, 0, 1, 0, 1);
    endtask

    task automatic t_cmp();
        drive(C_CMP, 8'h07, 8'h07, 1'b0, 1'b0, 1'b0);
        expect_all("R6 cmp equal", 8'h07, 0, 1, 1, 1, 1);
        drive(C_CMP, 8'h03, 8'h09, 1'b1, 1'b1, 1'b0);
        expect_all("R6 cmp less", 8'h03, 0, 0, 1, 0, 1);
        drive(C_CMP, 8'h09, 8'h03, 1'b1, 1'b0, 1'b0);
        expect_all("R6 cmp greater", 8'h09, 0, 0, 1, 1, 1);
    endtask

    task automatic t_xor();
        drive(C_XOR, 8'h5A, 8'h5A, 1'b0, 1'b1, 1'b0);
        expect_all("R7 xor zero", 8'h00, 1, 1, 1, 0, 1);
        drive(C_XOR, 8'hF0, 8'h0F, 1'b1, 1'b1, 1'b0);
        expect_all("R7 xor ones", 8'hFF, 1, 0, 1, 0, 1);
    endtask

    task automatic t_unary();
        drive(C_CPL, 8'h3C, 8'h00, 1'b1, 1'b0, 1'b0);
        expect_all("R8 cpl", 8'hC3, 1, 1, 0, 0, 0);
        drive(C_TST, 8'h00, 8'hFF, 1'b0, 1'b1, 1'b0);
        expect_all("R8 tst zero", 8'h00, 0, 1, 1, 1, 0);
        drive(C_TST, 8'h10, 8'h00, 1'b1, 1'b0, 1'b0);
        expect_all("R8 tst nonzero", 8'h10, 0, 0, 1, 0, 0);
        drive(C_CLR, 8'h77, 8'h00, 1'b0, 1'b1, 1'b0);
        expect_all("R8 clr", 8'h00, 1, 1, 1, 1, 0);
    endtask

    task automatic t_rotate();
        drive(C_ROR, 8'h81, 8'h00, 1'b1, 1'b0, 1'b0);
        expect_all("R9 ror", 8'hC0, 1, 1, 0, 1, 1);
        drive(C_ROL, 8'h81, 8'h00, 1'b0, 1'b0, 1'b0);
        expect_all("R9 rol", 8'h03, 1, 0, 0, 1, 1);
        drive(C_ROL, 8'h40, 8'h00, 1'b0, 1'b1, 1'b0);
        expect_all("R9 rol no carry", 8'h80, 1, 0, 0, 0, 1);
    endtask

    task automatic t_load();
        drive(C_LDR, 8'h33, 8'h00, 1'b0, 1'b1, 1'b0);
        expect_all("R10 ldr new zero", 8'h00, 1, 1, 1, 1, 0);
        drive(C_LDR, 8'h00, 8'h55, 1'b1, 1'b0, 1'b0);
        expect_all("R10 ldr new nonzero", 8'h55, 1, 0, 1, 0, 0);
        drive(C_LDR, 8'h33, 8'h00, 1'b0, 1'b0, 1'b1);
        expect_all("R10 ldr legacy", 8'h00, 1, 0, 0, 0, 0);
    endtask

    task automatic t_cond();
        drive(C_ADDC, 8'hFF, 8'h00, 1'b0, 1'b1, 1'b0);
        expect_all("R11 addc wrap", 8'h00, 1, 1, 1, 1, 1);
        drive(C_ADDC, 8'h05, 8'h00, 1'b1, 1'b1, 1'b0);
        expect_all("R11 addc inc", 8'h06, 1, 0, 1, 0, 1);
        drive(C_ADDC, 8'h05, 8'h00, 1'b1, 1'b0, 1'b0);
        expect_all("R11 addc skip", 8'h05, 0, 1, 0, 0, 0);
        drive(C_SUBNC, 8'h01, 8'h00, 1'b0, 1'b0, 1'b0);
        expect_all("R11 subnc zero", 8'h00, 1, 1, 1, 1, 1);
        drive(C_SUBNC, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0);
        expect_all("R11 subnc borrow", 8'hFF, 1, 0, 1, 0, 1);
        drive(C_SUBNC, 8'h05, 8'h00, 1'b0, 1'b1, 1'b0);
        expect_all("R11 subnc skip", 8'h05, 0, 0, 0, 1, 0);
    endtask

    task automatic t_shadow();
        drive(C_SAVE, 8'h12, 8'h00, 1'b1, 1'b0, 1'b0);
        expect_all("R12 save no write", 8'h12, 0, 1, 0, 0, 0);
        drive(C_REST, 8'h12, 8'h00, 1'b0, 1'b1, 1'b0);
        expect_all("R12 rest", 8'h12, 0, 1, 1, 0, 1);
        drive(C_SAVE, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0);
        drive(C_XOR, 8'hAA, 8'h55, 1'b1, 1'b0, 1'b0);
        drive(C_INC, 8'hFF, 8'h00, 1'b1, 1'b0, 1'b0);
        drive(C_REST, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0);
        expect_all("R12 rest after others", 8'h00, 0, 0, 1, 1, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_and_idle();
        t_inc_dec();
        t_add_sub();
        t_cmp();
        t_xor();
        t_unary();
        t_rotate();
        t_load();
        t_cond();
        t_shadow();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog got=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule